// File: doc/BRIEF.md
# CPU Hotplug Event Register Controller

This block keeps the hot-plug bookkeeping for a fixed set of processor slots and presents it to firmware through a small 12-byte little-endian register window. Firmware picks a slot by writing a selector, then reads that slot's flags (present, insert pending, remove pending), acknowledges events or asks for an eject through the same flags byte, and issues commands through a command byte paired with a 32-bit data word. A search command moves the selector to the next slot with a pending event, so a single loop in firmware can drain every event in turn.

Side-band inputs from the platform report a processor being plugged (cold or hot), an unplug being requested, and an unplug having completed. Any hot plug or unplug request raises a one-cycle interrupt pulse. Eject requests leave the block as a one-cycle pulse carrying the slot index. Status reports written by firmware leave it as a one-cycle pulse carrying the slot, the stored event code and the status code.

The window is seen as three 32-bit words with byte enables: word 0 (bytes 0..3) holds the selector, word 1 holds the flags byte in lane 0 (byte offset 4) and the command byte in lane 1 (byte offset 5), and word 2 (bytes 8..11) holds the data register. Reads are combinational from registered state and have no side effects.

Top module: `cpuhp_evt_ctrl`

## Requirements
- R1: After reset the selector is 0, the latched command is 0 (search), the outputs are low, and each slot's flags are zero except the present bit of slots marked present at boot.
- R2: A read of word 1 returns the selected slot's present flag in bit 0, insert pending in bit 1 and remove pending in bit 2; every other bit, including the command lane, reads 0; word 0 reads 0.
- R3: While the selector is not below the slot count, every read returns zero.
- R4: A write of the flags lane (word 1, lane 0) is decoded by priority: bit 1 clears insert pending; else bit 2 clears remove pending; else bit 3 requests eject.
- R5: An eject request produces a one-cycle eject pulse with the slot index on the cycle after the write, and is ignored when the selected slot is not present or is slot 0.
- R6: Writes to the selector (word 0) always take effect, lane by lane; writes to words 1 and 2 are dropped while the selector is out of range.
- R7: A write of the command lane (word 1, lane 1) latches values 0 (search), 1 (event code) and 2 (status code); values of 3 or more leave the command unchanged.
- R8: Writing command 0 moves the selector to the first slot, searching upward from the current selector and wrapping to 0, whose insert or remove flag is pending; with no pending slot the selector is unchanged.
- R9: A read of word 2 returns the selector while command 0 is latched and zero otherwise.
- R10: A word 2 write stores the selected slot's event code under command 1; under command 2 it stores the status code and on the next cycle pulses the report output with the slot, the stored event code and the new status code. Byte enables merge lane by lane.
- R11: A plug event marks the slot present; if it is a hot plug it also sets insert pending and pulses the interrupt on the next cycle, a cold plug does neither.
- R12: An unplug request sets remove pending and pulses the interrupt; unplug completion clears present; side-band events naming a slot at or above the slot count are ignored.
- R13: When a side-band event sets a flag in the same cycle as a firmware write clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_word | input | 2 | Word index in the window (0 selector, 1 flags/command, 2 data) |
| bus_be | input | 4 | Byte enables, lane 0 is the lowest address |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_rdata | output | 32 | Read data for bus_word, combinational |
| plug_valid | input | 1 | A processor was plugged into plug_slot |
| plug_slot | input | SW | Slot of the plug event |
| plug_hot | input | 1 | The plug was a hot plug |
| unreq_valid | input | 1 | Unplug requested for unreq_slot |
| unreq_slot | input | SW | Slot of the unplug request |
| undone_valid | input | 1 | Unplug finished for undone_slot |
| undone_slot | input | SW | Slot of the unplug completion |
| irq_pulse | output | 1 | One-cycle event interrupt |
| eject_valid | output | 1 | One-cycle eject request |
| eject_slot | output | SW | Slot to eject |
| report_valid | output | 1 | One-cycle status report |
| report_slot | output | SW | Slot of the report |
| report_event | output | 32 | Stored event code of that slot |
| report_status | output | 32 | Status code just written |

## Verification
The bench builds the block with five slots and slots 0 and 1 present at boot, so the slot count is not a power of two. With a 3-bit slot index, side-band indices 5 to 7 reach the out-of-range ignore path, selector values 5 and 6 reach the dropped-write and zero-read paths, and the wrapping search has to fold at 5 rather than at an index-width boundary. The boot-present slot 1 gives a legal eject target from the start, while slot 0 exercises the boot-processor refusal.

// File: rtl/cpuhp_pkg.sv
// Shared types and helpers for the CPU hotplug event register controller.
// Assumes a 32-bit data path split into four little-endian byte lanes.
package cpuhp_pkg;

    typedef enum logic [1:0] {
        CMD_SCAN = 2'd0,
        CMD_EVT  = 2'd1,
        CMD_STS  = 2'd2
    } cmd_e;

    localparam logic [1:0] WORD_SEL = 2'd0;
    localparam logic [1:0] WORD_CTL = 2'd1;
    localparam logic [1:0] WORD_DAT = 2'd2;

    localparam int CMD_LIMIT = 3;

    // Replace the enabled byte lanes of old_v by those of new_v.
    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be);
        logic [31:0] r;
        r = old_v;
        for (int b = 0; b < 4; b++) begin
            if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cpuhp_slot_state.sv
// Per-slot flag storage: present, insert pending, remove pending.
// Assumes the set/clear vectors are already decoded to one bit per slot.
// A set request wins over a clear request for the same flag in one cycle.
module cpuhp_slot_state #(
    parameter int               NSLOT        = 8,
    parameter logic [NSLOT-1:0] BOOT_PRESENT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] plug_v,
    input  logic [NSLOT-1:0] hot_v,
    input  logic [NSLOT-1:0] unreq_v,
    input  logic [NSLOT-1:0] done_v,
    input  logic [NSLOT-1:0] clr_ins_v,
    input  logic [NSLOT-1:0] clr_rmv_v,
    output logic [NSLOT-1:0] pres_v,
    output logic [NSLOT-1:0] ins_v,
    output logic [NSLOT-1:0] rmv_v
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        // Update the three flags of slot i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pres_v[i] <= BOOT_PRESENT[i];
                ins_v[i]  <= 1'b0;
                rmv_v[i]  <= 1'b0;
            end else begin
                if (plug_v[i])      pres_v[i] <= 1'b1;
                else if (done_v[i]) pres_v[i] <= 1'b0;

                if (plug_v[i] && hot_v[i]) ins_v[i] <= 1'b1;
                else if (clr_ins_v[i])     ins_v[i] <= 1'b0;

                if (unreq_v[i])         rmv_v[i] <= 1'b1;
                else if (clr_rmv_v[i])  rmv_v[i] <= 1'b0;
            end
        end

        // R12
        // unplug_clears_present_chk
        unplug_clears_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_v[i] && !plug_v[i]) |=> !pres_v[i]);

        // R13
        // set_beats_clear_chk
        set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (unreq_v[i] && clr_rmv_v[i]) |=> rmv_v[i]);
    end

endmodule

// File: rtl/cpuhp_next_scan.sv
// Combinational wrapping search: starting at 'start' and moving upward,
// returns the first slot whose pending bit is set, folding at NSLOT.
// Assumes start < NSLOT whenever the result is used.
module cpuhp_next_scan #(
    parameter  int NSLOT = 8,
    localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic [SW-1:0]    start,
    input  logic [NSLOT-1:0] pend,
    output logic             hit,
    output logic [SW-1:0]    idx
);

    // Walk the distances from far to near so the nearest hit is kept.
    always_comb begin
        hit = 1'b0;
        idx = start;
        for (int k = NSLOT - 1; k >= 0; k--) begin
            int j;
            j = int'(start) + k;
            if (j >= NSLOT) j = j - NSLOT;
            if (j < NSLOT && pend[SW'(j)]) begin
                hit = 1'b1;
                idx = SW'(j);
            end
        end
    end

endmodule

// File: rtl/cpuhp_evt_ctrl.sv
// CPU hotplug event register controller (top).
// Decodes a 3-word register window (selector, flags/command, data),
// keeps per-slot flags and status codes, and raises interrupt, eject and
// report pulses. Assumes one bus write per cycle; reads are side-effect free.
module cpuhp_evt_ctrl
    import cpuhp_pkg::*;
#(
    parameter  int               NSLOT        = 8,
    parameter  logic [NSLOT-1:0] BOOT_PRESENT = 1,
    localparam int               SW           = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [1:0]    bus_word,
    input  logic [3:0]    bus_be,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          plug_valid,
    input  logic [SW-1:0] plug_slot,
    input  logic          plug_hot,
    input  logic          unreq_valid,
    input  logic [SW-1:0] unreq_slot,
    input  logic          undone_valid,
    input  logic [SW-1:0] undone_slot,
    output logic          irq_pulse,
    output logic          eject_valid,
    output logic [SW-1:0] eject_slot,
    output logic          report_valid,
    output logic [SW-1:0] report_slot,
    output logic [31:0]   report_event,
    output logic [31:0]   report_status
);

    localparam logic [NSLOT-1:0] ONE_HOT0 = NSLOT'(1);

    logic [31:0]      sel_q;
    cmd_e             cmd_q;
    logic [31:0]      evt_q [NSLOT];
    logic [31:0]      sts_q [NSLOT];

    logic             sel_ok;
    logic [SW-1:0]    sel_i;
    logic [NSLOT-1:0] sel_oh;
    logic [NSLOT-1:0] pres_v, ins_v, rmv_v, pend_v;
    logic [NSLOT-1:0] plug_v, hot_v, unreq_v, done_v, clr_ins_v, clr_rmv_v;
    logic             wr_ctl, wr_dat, flag_wr, cmd_wr, scan_fire, ej_req;
    logic [7:0]       fbyte, cbyte;
    logic             scan_hit;
    logic [SW-1:0]    scan_idx;
    logic [31:0]      sts_merged;

    assign sel_ok = (sel_q < 32'(NSLOT));
    assign sel_i  = sel_q[SW-1:0];
    assign sel_oh = ONE_HOT0 << sel_i;
    assign pend_v = ins_v | rmv_v;
    assign fbyte  = bus_wdata[7:0];
    assign cbyte  = bus_wdata[15:8];

    // Qualify window writes; flags/command/data need an in-range selector.
    always_comb begin
        wr_ctl    = bus_wr && (bus_word == WORD_CTL) && sel_ok;
        wr_dat    = bus_wr && (bus_word == WORD_DAT) && sel_ok;
        flag_wr   = wr_ctl && bus_be[0];
        cmd_wr    = wr_ctl && bus_be[1] && (cbyte < 8'(CMD_LIMIT));
        scan_fire = cmd_wr && (cbyte == 8'd0);
        clr_ins_v = (flag_wr && fbyte[1]) ? sel_oh : '0;
        clr_rmv_v = (flag_wr && !fbyte[1] && fbyte[2]) ? sel_oh : '0;
        ej_req    = flag_wr && !fbyte[1] && !fbyte[2] && fbyte[3]
                    && pres_v[sel_i] && (sel_i != '0);
    end

    // Decode side-band slot indices into per-slot strobes.
    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            plug_v[i]  = plug_valid   && (plug_slot   == SW'(i));
            unreq_v[i] = unreq_valid  && (unreq_slot  == SW'(i));
            done_v[i]  = undone_valid && (undone_slot == SW'(i));
        end
        hot_v = {NSLOT{plug_hot}};
    end

    cpuhp_slot_state #(
        .NSLOT        (NSLOT),
        .BOOT_PRESENT (BOOT_PRESENT)
    ) slots_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .plug_v    (plug_v),
        .hot_v     (hot_v),
        .unreq_v   (unreq_v),
        .done_v    (done_v),
        .clr_ins_v (clr_ins_v),
        .clr_rmv_v (clr_rmv_v),
        .pres_v    (pres_v),
        .ins_v     (ins_v),
        .rmv_v     (rmv_v)
    );

    cpuhp_next_scan #(
        .NSLOT (NSLOT)
    ) scan_i (
        .start (sel_i),
        .pend  (pend_v),
        .hit   (scan_hit),
        .idx   (scan_idx)
    );

    // Selector: lane writes always accepted; search result moves it.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sel_q <= '0;
        else if (bus_wr && bus_word == WORD_SEL)
                                         sel_q <= lane_merge(sel_q, bus_wdata, bus_be);
        else if (scan_fire && scan_hit)  sel_q <= 32'(scan_idx);
    end

    // Command latch: only legal command codes are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= CMD_SCAN;
        else if (cmd_wr) cmd_q <= cmd_e'(cbyte[1:0]);
    end

    assign sts_merged = lane_merge(sts_q[sel_i], bus_wdata, bus_be);

    // Per-slot event and status code storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) begin
                evt_q[i] <= '0;
                sts_q[i] <= '0;
            end
        end else if (wr_dat && cmd_q == CMD_EVT) begin
            evt_q[sel_i] <= lane_merge(evt_q[sel_i], bus_wdata, bus_be);
        end else if (wr_dat && cmd_q == CMD_STS) begin
            sts_q[sel_i] <= sts_merged;
        end
    end

    // Registered output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse     <= 1'b0;
            eject_valid   <= 1'b0;
            eject_slot    <= '0;
            report_valid  <= 1'b0;
            report_slot   <= '0;
            report_event  <= '0;
            report_status <= '0;
        end else begin
            irq_pulse    <= (|(plug_v & hot_v)) || (|unreq_v);
            eject_valid  <= ej_req;
            eject_slot   <= ej_req ? sel_i : '0;
            report_valid <= wr_dat && (cmd_q == CMD_STS);
            if (wr_dat && cmd_q == CMD_STS) begin
                report_slot   <= sel_i;
                report_event  <= evt_q[sel_i];
                report_status <= sts_merged;
            end
        end
    end

    // Read mux over the window, all zero when the selector is out of range.
    always_comb begin
        bus_rdata = '0;
        if (sel_ok) begin
            case (bus_word)
                WORD_CTL: bus_rdata[2:0] = {rmv_v[sel_i], ins_v[sel_i], pres_v[sel_i]};
                WORD_DAT: if (cmd_q == CMD_SCAN) bus_rdata = sel_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R5
    // eject_never_boot_chk
    eject_never_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eject_valid |-> (eject_slot != '0));

    // R7
    // cmd_legal_chk
    cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_SCAN) || (cmd_q == CMD_EVT) || (cmd_q == CMD_STS));

    // R8
    // scan_lands_pending_chk
    scan_lands_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_fire && scan_hit && !bus_be[0]) |=> (ins_v[sel_i] || rmv_v[sel_i]));

    // R6
    // oor_write_drop_chk
    oor_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !sel_ok && bus_word != WORD_SEL) |=> ($stable(cmd_q) && $stable(sel_q)));

    // R11
    // irq_has_cause_chk
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past((plug_valid && plug_hot) || unreq_valid));

endmodule

// File: tb/cpuhp_evt_ctrl_tb_top.sv
`timescale 1ns/10ps
module cpuhp_evt_ctrl_tb_top;

    localparam int NS = 5;
    localparam int SW = 3;
    localparam logic [NS-1:0] BOOT = 5'b00011;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_wr;
    logic [1:0]    bus_word;
    logic [3:0]    bus_be;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic          plug_valid, plug_hot, unreq_valid, undone_valid;
    logic [SW-1:0] plug_slot, unreq_slot, undone_slot;
    logic          irq_pulse, eject_valid, report_valid;
    logic [SW-1:0] eject_slot, report_slot;
    logic [31:0]   report_event, report_status;

    always #2 clk = ~clk;

    cpuhp_evt_ctrl #(.NSLOT(NS), .BOOT_PRESENT(BOOT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .plug_valid(plug_valid), .plug_slot(plug_slot), .plug_hot(plug_hot),
        .unreq_valid(unreq_valid), .unreq_slot(unreq_slot),
        .undone_valid(undone_valid), .undone_slot(undone_slot),
        .irq_pulse(irq_pulse), .eject_valid(eject_valid), .eject_slot(eject_slot),
        .report_valid(report_valid), .report_slot(report_slot),
        .report_event(report_event), .report_status(report_status));

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    // Reference model state
    logic [NS-1:0] m_pres, m_ins, m_rmv;
    logic [31:0]   m_sel;
    int            m_cmd;
    logic [31:0]   m_evt [NS];
    logic [31:0]   m_sts [NS];
    logic          e_irq, e_ej, e_rpt;
    logic [SW-1:0] e_ej_slot, e_rpt_slot;
    logic [31:0]   e_rpt_evt, e_rpt_sts;

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(logic [1:0] w);
        if (m_sel >= NS) return 32'd0;
        if (w == 2'd1) return {29'd0, m_rmv[m_sel], m_ins[m_sel], m_pres[m_sel]};
        if (w == 2'd2) return (m_cmd == 0) ? m_sel : 32'd0;
        return 32'd0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_wr = 0; bus_word = 0; bus_be = 0; bus_wdata = 0;
        plug_valid = 0; plug_slot = 0; plug_hot = 0;
        unreq_valid = 0; unreq_slot = 0; undone_valid = 0; undone_slot = 0;
    endtask

    task automatic clear_exp();
        e_irq = 0; e_ej = 0; e_rpt = 0;
        e_ej_slot = 0; e_rpt_slot = 0; e_rpt_evt = 0; e_rpt_sts = 0;
    endtask

    // Advance one edge and check the pulse outputs against expectations.
    task automatic step_chk(string req);
        @(posedge clk); #1;
        idle();
        chk({req, " irq"}, 32'(irq_pulse), 32'(e_irq));
        chk({req, " eject"}, 32'(eject_valid), 32'(e_ej));
        if (e_ej) chk({req, " eject slot"}, 32'(eject_slot), 32'(e_ej_slot));
        chk({req, " report"}, 32'(report_valid), 32'(e_rpt));
        if (e_rpt) begin
            chk({req, " report slot"}, 32'(report_slot), 32'(e_rpt_slot));
            chk({req, " report event"}, report_event, e_rpt_evt);
            chk({req, " report status"}, report_status, e_rpt_sts);
        end
    endtask

    task automatic rd_chk(string req, logic [1:0] w);
        bus_word = w; #0.2;
        chk(req, bus_rdata, exp_read(w));
    endtask

    task automatic rd_all(string req);
        rd_chk({req, " word0"}, 2'd0);
        rd_chk({req, " flags"}, 2'd1);
        rd_chk({req, " data"}, 2'd2);
        bus_word = 0;
    endtask

    function automatic void model_scan();
        for (int k = 0; k < NS; k++) begin
            int j = (int'(m_sel) + k) % NS;
            if (m_ins[j] || m_rmv[j]) begin
                m_sel = 32'(j);
                return;
            end
        end
    endfunction

    // Bus write with model update (R4..R10).
    task automatic bus_w(string req, logic [1:0] w, logic [3:0] be, logic [31:0] d);
        bit sok = (m_sel < NS);
        clear_exp();
        bus_wr = 1; bus_word = w; bus_be = be; bus_wdata = d;
        if (w == 2'd0) m_sel = merge(m_sel, d, be);
        else if (w == 2'd1 && sok) begin
            if (be[0]) begin
                if (d[1])      m_ins[m_sel] = 0;
                else if (d[2]) m_rmv[m_sel] = 0;
                else if (d[3] && m_pres[m_sel] && m_sel != 0) begin
                    e_ej = 1; e_ej_slot = m_sel[SW-1:0];
                end
            end
            if (be[1] && d[15:8] < 3) begin
                m_cmd = int'(d[15:8]);
                if (m_cmd == 0) model_scan();
            end
        end else if (w == 2'd2 && sok) begin
            if (m_cmd == 1) m_evt[m_sel] = merge(m_evt[m_sel], d, be);
            else if (m_cmd == 2) begin
                m_sts[m_sel] = merge(m_sts[m_sel], d, be);
                e_rpt = 1; e_rpt_slot = m_sel[SW-1:0];
                e_rpt_evt = m_evt[m_sel]; e_rpt_sts = m_sts[m_sel];
            end
        end
        step_chk(req);
    endtask

    // Side-band event: kind 0 plug, 1 unplug request, 2 unplug done (R11, R12).
    task automatic sb(string req, int kind, logic [SW-1:0] s, logic hot);
        clear_exp();
        case (kind)
            0: begin
                plug_valid = 1; plug_slot = s; plug_hot = hot;
                if (s < NS) begin
                    m_pres[s] = 1;
                    if (hot) begin m_ins[s] = 1; e_irq = 1; end
                end
            end
            1: begin
                unreq_valid = 1; unreq_slot = s;
                if (s < NS) begin m_rmv[s] = 1; e_irq = 1; end
            end
            default: begin
                undone_valid = 1; undone_slot = s;
                if (s < NS) m_pres[s] = 0;
            end
        endcase
        step_chk(req);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        rst_n = 0;
        m_pres = BOOT; m_ins = 0; m_rmv = 0; m_sel = 0; m_cmd = 0;
        for (int i = 0; i < NS; i++) begin m_evt[i] = 0; m_sts[i] = 0; end
        clear_exp();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        chk("R1 irq", 32'(irq_pulse), 0);
        chk("R1 eject", 32'(eject_valid), 0);
        chk("R1 report", 32'(report_valid), 0);
        rd_all("R1 reset");
        chk("R1 slot0 flags", exp_read(2'd1), 32'd1);
        bus_w("R6 sel write", 2'd0, 4'b1111, 32'd2);
        rd_chk("R1 slot2 not present", 2'd1);

        // R11 hot plug vs cold plug
        sb("R11 hot plug", 0, 3'd3, 1'b1);
        sb("R11 cold plug", 0, 3'd4, 1'b0);
        bus_w("R6 sel", 2'd0, 4'b0001, 32'd3);
        bus_word = 2'd1; #0.2; chk("R2 hot flags", bus_rdata, 32'd3);
        bus_w("R6 sel", 2'd0, 4'b0001, 32'd4);
        bus_word = 2'd1; #0.2; chk("R2 cold flags", bus_rdata, 32'd1);

        // R12 unplug request, out-of-range side-band
        sb("R12 unreq", 1, 3'd1, 1'b0);
        sb("R12 oor plug", 0, 3'd6, 1'b1);
        sb("R12 oor unreq", 1, 3'd7, 1'b0);

        // R8 wrapping search from 4: slot 1 (remove) before slot 3
        bus_w("R8 scan", 2'd1, 4'b0010, 32'h0000_0000);
        bus_word = 2'd2; #0.2; chk("R8 R9 scan wrap", bus_rdata, 32'd1);
        rd_all("R8");

        // R4 priority: bits 1|2 clear only insert (none at 1), remove stays
        bus_w("R4 prio", 2'd1, 4'b0001, 32'h06);
        bus_word = 2'd1; #0.2; chk("R4 remove kept", bus_rdata, 32'd5);
        bus_w("R4 clr rmv", 2'd1, 4'b0001, 32'h04);
        bus_word = 2'd1; #0.2; chk("R4 remove cleared", bus_rdata, 32'd1);

        // R5 eject cases
        bus_w("R6 sel0", 2'd0, 4'b1111, 32'd0);
        bus_w("R5 eject boot", 2'd1, 4'b0001, 32'h08);
        bus_w("R6 sel2", 2'd0, 4'b1111, 32'd2);
        bus_w("R5 eject absent", 2'd1, 4'b0001, 32'h08);
        bus_w("R6 sel4", 2'd0, 4'b1111, 32'd4);
        bus_w("R5 eject ok", 2'd1, 4'b0001, 32'h0a);
        bus_w("R5 eject ok", 2'd1, 4'b0001, 32'h08);

        // R7 command legality, R9, R10
        bus_w("R7 cmd3", 2'd1, 4'b0010, 32'h0000_0300);
        rd_chk("R7 R9 cmd kept", 2'd2);
        bus_w("R7 cmd1", 2'd1, 4'b0010, 32'h0000_0100);
        rd_chk("R9 data zero", 2'd2);
        bus_w("R10 evt", 2'd2, 4'b1111, 32'hA5A5_0103);
        bus_w("R7 cmd2", 2'd1, 4'b0010, 32'h0000_0200);
        bus_w("R10 sts", 2'd2, 4'b0011, 32'h1234_5678);

        // R3 / R6 out-of-range selector
        bus_w("R6 sel6", 2'd0, 4'b1111, 32'd6);
        rd_all("R3 oor");
        bus_w("R6 oor cmd", 2'd1, 4'b0010, 32'h0000_0000);
        bus_w("R6 oor data", 2'd2, 4'b1111, 32'hFFFF_FFFF);
        bus_w("R6 back", 2'd0, 4'b0001, 32'd4);
        rd_all("R6 cmd unchanged");

        // R8 no pending: selector unchanged
        bus_w("R7 cmd0", 2'd1, 4'b0010, 32'h0000_0000);
        bus_w("R4 clr ins3", 2'd0, 4'b0001, 32'd3);
        bus_w("R4 clr ins3", 2'd1, 4'b0001, 32'h02);
        bus_w("R8 none", 2'd1, 4'b0010, 32'h0000_0000);
        bus_word = 2'd2; #0.2; chk("R8 unchanged", bus_rdata, 32'd3);

        // R12 unplug done clears present
        sb("R12 done", 2, 3'd3, 1'b0);
        rd_all("R12 absent");

        // R13 remove set beats same-cycle clear
        bus_w("R13 sel", 2'd0, 4'b1111, 32'd2);
        clear_exp();
        bus_wr = 1; bus_word = 2'd1; bus_be = 4'b0001; bus_wdata = 32'h04;
        unreq_valid = 1; unreq_slot = 3'd2;
        m_rmv[2] = 1; e_irq = 1;
        step_chk("R13 conflict");
        bus_word = 2'd1; #0.2; chk("R13 remove set", bus_rdata, 32'd4);

        // Random phase
        for (int it = 0; it < 600; it++) begin
            int op = int'($urandom % 8);
            logic [3:0] be;
            case (op)
                0: sb("R11 rnd", 0, SW'($urandom % 8), 1'($urandom % 2));
                1: sb("R12 rnd", 1, SW'($urandom % 8), 1'b0);
                2: sb("R12 rnd", 2, SW'($urandom % 8), 1'b0);
                3: bus_w("R6 rnd", 2'd0, 4'b1111, 32'($urandom % 7));
                4: bus_w("R4 R5 rnd", 2'd1, 4'b0001, 32'($urandom % 16));
                5: bus_w("R7 R8 rnd", 2'd1, 4'b0010, {16'd0, 8'($urandom % 5), 8'd0});
                6: begin
                    be = 4'($urandom % 15) + 4'd1;
                    bus_w("R10 rnd", 2'd2, be, $urandom);
                end
                default: begin clear_exp(); step_chk("R2 rnd idle"); end
            endcase
            rd_all("R2 R3 R9 rnd");
        end

        finish_run();
    end

endmodule